// File: doc/BRIEF.md
# Multi-PLL Lock Status Filter

This block turns the raw lock flags of one transmit PLL and a parameterised number of receive PLLs into a single, debounced lock indication. All timing is counted in cycles of the reference clock (125 MHz by default). The indication is raised only after every raw flag has been high without a break for a qualifying interval. It is dropped only after the combined condition has been low without a break for a longer interval, so short dropouts on any PLL do not reach the output.

An active-low external reset pulls the indication low at once, without waiting for a clock edge. After that reset is released, a minimum low time must pass before the indication may rise again. The output models an open-collector pin as a drive enable plus a drive level. The level is always zero, so the board-level signal is low while the enable is set and is pulled high by an external resistor otherwise. Several such pins can therefore share one wired-AND line. The raw flags are asynchronous to the count clock and are resynchronised before use.

Top module: `lock_qual_top`

## Requirements
- R1: The qualifying condition is the AND of `tx_lock_raw` and every bit of `rx_lock_raw`. While any one flag is held low, the output never reports lock.
- R2: Starting from an unlocked state with the hold time already served, the output reports lock on the ASSERT_CYCLES-th consecutive clock edge at which the synchronised condition is high.
- R3: Once locked, the output reports loss of lock on the DEASSERT_CYCLES-th consecutive edge at which the synchronised condition is low. Any single flag going low is enough to start this count.
- R4: While `ext_rst_n` is low, `lock_drv_en` is 1 in the same cycle, before any clock edge, and the locked state is cleared at the next edge.
- R5: After `ext_rst_n` returns high, the output keeps reporting no lock until at least HOLD_CYCLES edges have passed with `ext_rst_n` high. With all flags already high, lock is reported at edge max(ASSERT_CYCLES, HOLD_CYCLES) after the release.
- R6: A single-cycle interruption of the condition restarts the running count from zero. A one-cycle dropout while locked does not drop lock. A one-cycle dropout while qualifying delays lock by a full ASSERT_CYCLES measured from the recovery.
- R7: Open-collector encoding: `lock_drv_val` is always 0. `lock_drv_en` = 1 means the pin is pulled low (no lock), and `lock_drv_en` = 0 means the pin is released (lock).
- R8: Raw flags pass through a SYNC_STAGES-flop synchroniser (default 2). A change of a raw flag reaches the counters SYNC_STAGES edges later, so with defaults lock appears at edge 2 + ASSERT_CYCLES after all flags rise.
- R9: Synchronous active-high `rst` clears the synchroniser, all counters and the locked state. `lock_drv_en` is 1 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference count clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_rst_n | input | 1 | External active-low reset; forces no-lock and restarts the hold time |
| tx_lock_raw | input | 1 | Raw lock flag of the transmit PLL (asynchronous) |
| rx_lock_raw | input | NUM_RX | Raw lock flags of the receive PLLs (asynchronous) |
| lock_drv_en | output | 1 | Open-collector drive enable; 1 pulls the lock pin low |
| lock_drv_val | output | 1 | Open-collector drive level; constant 0 |

## Verification
A wrong count value or a stuck state in this block shows at the ports as a lock edge that arrives one or more cycles early or late compared with 2 + ASSERT_CYCLES (or 2 + DEASSERT_CYCLES) after the raw change. A state that fails to clear shows as lock that survives an external reset, or as lock that returns before the hold time has run out. A counter that is not cleared by a dropout shows as a lock transition too early after a glitch. The bench uses short threshold values, so each such error appears within a few tens of cycles of the stimulus. It samples the exact edge before and after each expected transition.

// File: rtl/lock_pkg.sv
package lock_pkg;

    typedef enum logic {
        LK_UNLOCKED = 1'b0,
        LK_LOCKED   = 1'b1
    } lock_state_e;

    typedef struct packed {
        logic clr;
        logic inc;
    } cnt_ctl_t;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/lock_sync.sv
module lock_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [STAGES-1:0][WIDTH-1:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) pipe[0] <= '0;
        else     pipe[0] <= d_async;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) pipe[s] <= '0;
            else     pipe[s] <= pipe[s-1];
        end
    end

    assign q_sync = pipe[STAGES-1];
endmodule

// File: rtl/lock_run_counter.sv
module lock_run_counter
    import lock_pkg::*;
#(
    parameter int LIMIT = 16
) (
    input  logic     clk,
    input  logic     rst,
    input  cnt_ctl_t ctl,
    output logic     done_now
);
    localparam int            CW   = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] TOP  = CW'(LIMIT);
    localparam logic [CW-1:0] TRIG = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || ctl.clr)               cnt <= '0;
        else if (ctl.inc && cnt != TOP)   cnt <= cnt + 1'b1;
    end

    // this edge is the LIMIT-th consecutive counted edge (or later)
    assign done_now = ctl.inc && !ctl.clr && (cnt >= TRIG);
endmodule

// File: rtl/lock_qual_top.sv
module lock_qual_top
    import lock_pkg::*;
#(
    parameter int NUM_RX          = 2,
    parameter int ASSERT_CYCLES   = 49250,
    parameter int DEASSERT_CYCLES = 131625,
    parameter int HOLD_CYCLES     = 49250,
    parameter int SYNC_STAGES     = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ext_rst_n,
    input  logic              tx_lock_raw,
    input  logic [NUM_RX-1:0] rx_lock_raw,
    output logic              lock_drv_en,
    output logic              lock_drv_val
);
    localparam int NFLAG = NUM_RX + 1;

    logic [NFLAG-1:0] flags_s;
    logic             ok_sync;
    lock_state_e      state_q;
    logic             locked_q;
    cnt_ctl_t         good_ctl, bad_ctl, hold_ctl;
    logic             good_done, bad_done, hold_done;

    lock_sync #(.WIDTH(NFLAG), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async ({rx_lock_raw, tx_lock_raw}),
        .q_sync  (flags_s)
    );

    assign ok_sync  = &flags_s;
    assign locked_q = (state_q == LK_LOCKED);

    always_comb begin
        good_ctl.inc = ok_sync;
        good_ctl.clr = !ok_sync || !ext_rst_n;
        bad_ctl.inc  = !ok_sync;
        bad_ctl.clr  = ok_sync || !locked_q || !ext_rst_n;
        hold_ctl.inc = ext_rst_n;
        hold_ctl.clr = !ext_rst_n;
    end

    lock_run_counter #(.LIMIT(ASSERT_CYCLES)) u_good (
        .clk (clk), .rst (rst), .ctl (good_ctl), .done_now (good_done)
    );

    lock_run_counter #(.LIMIT(DEASSERT_CYCLES)) u_bad (
        .clk (clk), .rst (rst), .ctl (bad_ctl), .done_now (bad_done)
    );

    lock_run_counter #(.LIMIT(HOLD_CYCLES)) u_hold (
        .clk (clk), .rst (rst), .ctl (hold_ctl), .done_now (hold_done)
    );

    always_ff @(posedge clk) begin
        if (rst || !ext_rst_n) begin
            state_q <= LK_UNLOCKED;
        end else begin
            unique case (state_q)
                LK_UNLOCKED: if (good_done && hold_done) state_q <= LK_LOCKED;
                LK_LOCKED:   if (bad_done)               state_q <= LK_UNLOCKED;
                default:                                 state_q <= LK_UNLOCKED;
            endcase
        end
    end

    // open-collector model: pull low whenever not locked or reset is held
    assign lock_drv_en  = !locked_q || !ext_rst_n;
    assign lock_drv_val = 1'b0;
endmodule

// File: rtl/lock_qual_chk.sv
module lock_qual_chk #(
    parameter int NUM_RX          = 2,
    parameter int ASSERT_CYCLES   = 49250,
    parameter int DEASSERT_CYCLES = 131625,
    parameter int HOLD_CYCLES     = 49250
) (
    input logic              clk,
    input logic              rst,
    input logic              ext_rst_n,
    input logic              tx_lock_raw,
    input logic [NUM_RX-1:0] rx_lock_raw,
    input logic              ok_sync,
    input logic              locked_q
);
    logic [31:0] ok_run, bad_run, hold_run;
    logic [1:0]  since_rst;
    logic        raw_all;

    assign raw_all = tx_lock_raw && (&rx_lock_raw);

    always_ff @(posedge clk) begin
        if (rst) begin
            ok_run    <= '0;
            bad_run   <= '0;
            hold_run  <= '0;
            since_rst <= '0;
        end else begin
            ok_run    <= (ok_sync && ext_rst_n) ? ((ok_run == '1) ? ok_run : ok_run + 1) : '0;
            bad_run   <= (!ok_sync) ? ((bad_run == '1) ? bad_run : bad_run + 1) : '0;
            hold_run  <= ext_rst_n ? ((hold_run == '1) ? hold_run : hold_run + 1) : '0;
            since_rst <= (since_rst == 2'd3) ? since_rst : since_rst + 1'b1;
        end
    end

    // R1
    no_lock_without_cond_chk: assert property (@(posedge clk) disable iff (rst)
        (!ok_sync && !locked_q) |=> !locked_q);

    // R2
    assert_after_run_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(locked_q) |-> (ok_run >= 32'(ASSERT_CYCLES)));

    // R3
    deassert_after_run_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(locked_q) && $past(ext_rst_n)) |-> (bad_run >= 32'(DEASSERT_CYCLES)));

    // R4
    ext_reset_clears_chk: assert property (@(posedge clk) disable iff (rst)
        !ext_rst_n |=> !locked_q);

    // R5
    hold_time_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(locked_q) |-> (hold_run >= 32'(HOLD_CYCLES)));

    // R6
    stay_locked_chk: assert property (@(posedge clk) disable iff (rst)
        (locked_q && ok_sync && ext_rst_n) |=> locked_q);

    // R8
    sync_latency_chk: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 2'd3) |-> (ok_sync == $past(raw_all, 2)));
endmodule

bind lock_qual_top lock_qual_chk #(
    .NUM_RX          (NUM_RX),
    .ASSERT_CYCLES   (ASSERT_CYCLES),
    .DEASSERT_CYCLES (DEASSERT_CYCLES),
    .HOLD_CYCLES     (HOLD_CYCLES)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .ext_rst_n   (ext_rst_n),
    .tx_lock_raw (tx_lock_raw),
    .rx_lock_raw (rx_lock_raw),
    .ok_sync     (ok_sync),
    .locked_q    (locked_q)
);

// File: tb/tb_lock_qual_top.sv
`timescale 1ns/1ps
module tb_lock_qual_top;
    localparam int NA = 20;
    localparam int ND = 40;
    localparam int NH = 30;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ext_rst_n = 1'b1;
    logic       tx_raw = 1'b0;
    logic [1:0] rx_raw = 2'b00;
    logic       drv_en, drv_val;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    lock_qual_top #(
        .NUM_RX(2), .ASSERT_CYCLES(NA), .DEASSERT_CYCLES(ND),
        .HOLD_CYCLES(NH), .SYNC_STAGES(2)
    ) dut (
        .clk(clk), .rst(rst), .ext_rst_n(ext_rst_n),
        .tx_lock_raw(tx_raw), .rx_lock_raw(rx_raw),
        .lock_drv_en(drv_en), .lock_drv_val(drv_val)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            failures++;
            $display("FAIL watchdog (all requirements) actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input logic act, input logic exp, input string req, input string what);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic t_reset();   // R9, R7
        @(negedge clk);
        chk(drv_en, 1'b1, "R9", "pin pulled low during reset");
        step(3);
        rst = 1'b0;
        step(1);
        chk(drv_en, 1'b1, "R9", "pin pulled low after reset");
        chk(drv_val, 1'b0, "R7", "drive level is zero");
    endtask

    task automatic t_partial(); // R1
        tx_raw = 1'b1;
        rx_raw = 2'b01;
        step(3 * NA);
        chk(drv_en, 1'b1, "R1", "no lock with one rx flag low");
    endtask

    task automatic t_assert();  // R2, R8
        rx_raw = 2'b11;
        step(NA + 1);
        chk(drv_en, 1'b1, "R2", "not locked one edge early");
        step(1);
        chk(drv_en, 1'b0, "R8", "locked at sync delay plus assert count");
        chk(drv_val, 1'b0, "R7", "drive level zero while released");
    endtask

    task automatic t_glitch_locked(); // R6
        rx_raw[0] = 1'b0;
        step(1);
        rx_raw[0] = 1'b1;
        step(ND + 5);
        chk(drv_en, 1'b0, "R6", "one-cycle dropout keeps lock");
    endtask

    task automatic t_deassert_tx(); // R3
        tx_raw = 1'b0;
        step(ND + 1);
        chk(drv_en, 1'b0, "R3", "tx dropout: still locked one edge early");
        step(1);
        chk(drv_en, 1'b1, "R3", "tx dropout: unlock at deassert count");
    endtask

    task automatic t_glitch_qual(); // R6
        tx_raw = 1'b1;
        step(10);
        tx_raw = 1'b0;
        step(1);
        tx_raw = 1'b1;
        step(NA + 1);
        chk(drv_en, 1'b1, "R6", "count restarted after glitch");
        step(1);
        chk(drv_en, 1'b0, "R6", "lock after full count from recovery");
    endtask

    task automatic t_deassert_rx(); // R3
        rx_raw[1] = 1'b0;
        step(ND + 1);
        chk(drv_en, 1'b0, "R3", "rx1 dropout: still locked one edge early");
        step(1);
        chk(drv_en, 1'b1, "R3", "rx1 dropout: unlock at deassert count");
        rx_raw[1] = 1'b1;
        step(NA + 2);
        chk(drv_en, 1'b0, "R2", "relock after rx1 recovery");
    endtask

    task automatic t_ext_reset(); // R4, R5
        ext_rst_n = 1'b0;
        #1;
        chk(drv_en, 1'b1, "R4", "pin pulled low before any edge");
        step(5);
        chk(drv_en, 1'b1, "R4", "pin low while reset held");
        chk(drv_val, 1'b0, "R7", "drive level zero in reset");
        ext_rst_n = 1'b1;
        step(NH - 1);
        chk(drv_en, 1'b1, "R5", "hold time not yet served");
        step(1);
        chk(drv_en, 1'b0, "R5", "lock after hold time");
    endtask

    initial begin
        t_reset();
        t_partial();
        t_assert();
        t_glitch_locked();
        t_deassert_tx();
        t_glitch_qual();
        t_deassert_rx();
        t_ext_reset();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule